// File: doc/BRIEF.md
# Serial Flash Fast-Read Responder

This block is the read side of a serial flash slave. It runs entirely on the serial clock and stays idle while the active-low select is high. Once select falls, it shifts in an opcode, a 24-bit start address and one dummy byte on the serial input, sampling on rising clock edges. If the opcode is the fast-read code and no write cycle is running, it streams array bytes out on the serial output. Bits change on falling edges, most significant bit first.

The block fetches each byte through a synchronous read port. That port captures the address on the rising edge where the read strobe is high and holds the data until the next read. The block issues each fetch early enough that the data is waiting when the byte's first falling edge arrives. The address steps by one after every byte and wraps from the top of the address space back to zero, so a single command can sweep the whole array indefinitely. Raising select stops the stream at once and clears every register.

Top module: `fastread_responder`

## Requirements
- R1: The header is 40 bits sampled on rising SCK edges. It consists of an 8-bit opcode, then a 24-bit address, then 8 dummy bits, each field MSB first. Only opcode 0x0B with `busy` low at the 8th rising edge selects the read.
- R2: `so_oe` is 0 for all 40 header clocks, and while select is high.
- R3: Data bits change on falling SCK edges, MSB first. Bit 7 of the first byte appears on the falling edge that follows the 40th rising edge.
- R4: The first read strobe carries the header address. Each following strobe carries the previous address plus one, with one strobe per output byte.
- R5: After address 0xFFFFFF the next byte is read from 0x000000, with no gap in the output stream.
- R6: Raising `cs_n`, including in the middle of a byte, drops `so_oe` at once. The next command starts from a clean header.
- R7: When `busy` is 1 at the 8th rising edge, the command is ignored. No read strobe is issued and `so_oe` stays 0 until select rises.
- R8: A non-matching opcode issues no read strobe and keeps `so_oe` at 0 until select rises.
- R9: `rst` high at an SCK edge returns the block to the start of a header, with `so_oe` and `mem_rd_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select; high clears the block asynchronously |
| si | input | 1 | Serial data in, sampled on rising SCK |
| busy | input | 1 | High while a write cycle is in progress |
| so | output | 1 | Serial data out, changes on falling SCK |
| so_oe | output | 1 | Output enable for `so`; 0 means high impedance |
| mem_rd_en | output | 1 | Read strobe to the array |
| mem_addr | output | 24 | Read address to the array |
| mem_rd_data | input | 8 | Array data, registered on the strobed rising edge |

## Verification
The checker assumes that select changes only while SCK is low. It also assumes that `rst` and `cs_n` stay steady from one edge to the next, so every property is disabled while either is asserted. The checker further relies on the array answering one edge after the strobe and holding its data until the next strobe. The bench drives `si`, `busy`, `cs_n` and `rst` only on falling edges and models the array with exactly that latency. It compares `so` and `so_oe` after every rising edge with a bit stream computed from the address.

// File: rtl/fastread_pkg.sv
package fastread_pkg;
    localparam int ADDR_W   = 24;
    localparam int DATA_W   = 8;
    localparam int OPC_W    = 8;
    localparam int DUMMY_W  = 8;
    localparam logic [OPC_W-1:0] OPC_FAST_READ = 8'h0B;

    localparam int HDR_BITS = OPC_W + ADDR_W + DUMMY_W;
    localparam int CNT_W    = $clog2(HDR_BITS + 1);
    localparam int BIT_W    = $clog2(DATA_W);

    typedef enum logic [1:0] {
        PH_OPCODE,
        PH_ADDRESS,
        PH_DUMMY,
        PH_STREAM
    } phase_e;

    function automatic phase_e phase_of(input logic [CNT_W-1:0] cnt);
        if (cnt < CNT_W'(OPC_W))
            return PH_OPCODE;
        else if (cnt < CNT_W'(OPC_W + ADDR_W))
            return PH_ADDRESS;
        else if (cnt < CNT_W'(HDR_BITS))
            return PH_DUMMY;
        else
            return PH_STREAM;
    endfunction
endpackage

// File: rtl/fastread_rx.sv
module fastread_rx
    import fastread_pkg::*;
(
    input  logic              sck,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              si,
    input  logic              busy,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              in_stream,
    output logic              accepted
);
    logic [CNT_W-1:0]  hdr_cnt;
    logic [OPC_W-1:0]  opc_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BIT_W-1:0]  beat_q;
    logic              acc_q;
    phase_e            phase;

    assign phase     = phase_of(hdr_cnt);
    assign in_stream = (phase == PH_STREAM);
    assign accepted  = acc_q;
    assign mem_addr  = addr_q;

    // Prefetch on the last dummy bit, then once per byte on its last beat.
    assign mem_rd_en = acc_q &&
                       ((hdr_cnt == CNT_W'(HDR_BITS - 1)) ||
                        (in_stream && beat_q == BIT_W'(DATA_W - 1)));

    always_ff @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            hdr_cnt <= '0;
            opc_q   <= '0;
            addr_q  <= '0;
            beat_q  <= '0;
            acc_q   <= 1'b0;
        end else if (rst) begin
            hdr_cnt <= '0;
            opc_q   <= '0;
            addr_q  <= '0;
            beat_q  <= '0;
            acc_q   <= 1'b0;
        end else begin
            if (!in_stream)
                hdr_cnt <= hdr_cnt + 1'b1;
            if (phase == PH_OPCODE)
                opc_q <= {opc_q[OPC_W-2:0], si};
            if (hdr_cnt == CNT_W'(OPC_W - 1))
                acc_q <= ({opc_q[OPC_W-2:0], si} == OPC_FAST_READ) && !busy;
            if (phase == PH_ADDRESS)
                addr_q <= {addr_q[ADDR_W-2:0], si};
            else if (mem_rd_en)
                addr_q <= addr_q + 1'b1;
            if (in_stream)
                beat_q <= beat_q + 1'b1;
        end
    end
endmodule

// File: rtl/fastread_tx.sv
module fastread_tx
    import fastread_pkg::*;
(
    input  logic              sck,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              go,
    input  logic [DATA_W-1:0] rd_data,
    output logic              so,
    output logic              so_oe
);
    logic [DATA_W-1:0] shreg;
    logic [BIT_W-1:0]  fbit;
    logic              oe_q;

    always_ff @(negedge sck or posedge cs_n) begin
        if (cs_n) begin
            shreg <= '0;
            fbit  <= '0;
            oe_q  <= 1'b0;
        end else if (rst) begin
            shreg <= '0;
            fbit  <= '0;
            oe_q  <= 1'b0;
        end else if (go) begin
            if (fbit == '0)
                shreg <= rd_data;
            else
                shreg <= {shreg[DATA_W-2:0], 1'b0};
            fbit <= fbit + 1'b1;
            oe_q <= 1'b1;
        end
    end

    assign so    = shreg[DATA_W-1];
    assign so_oe = oe_q;
endmodule

// File: rtl/fastread_responder.sv
module fastread_responder
    import fastread_pkg::*;
(
    input  logic              sck,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              si,
    input  logic              busy,
    output logic              so,
    output logic              so_oe,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rd_data
);
    logic in_stream;
    logic acc_q;

    fastread_rx u_rx (
        .sck       (sck),
        .rst       (rst),
        .cs_n      (cs_n),
        .si        (si),
        .busy      (busy),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .in_stream (in_stream),
        .accepted  (acc_q)
    );

    fastread_tx u_tx (
        .sck     (sck),
        .rst     (rst),
        .cs_n    (cs_n),
        .go      (in_stream && acc_q),
        .rd_data (mem_rd_data),
        .so      (so),
        .so_oe   (so_oe)
    );
endmodule

// File: rtl/fastread_responder_chk.sv
module fastread_responder_chk
    import fastread_pkg::*;
(
    input logic              sck,
    input logic              rst,
    input logic              cs_n,
    input logic              so_oe,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              in_stream,
    input logic              acc_q
);
    // Output stays released until the header has been fully taken in.
    assert_hiz_header_R2: assert property (@(posedge sck) disable iff (cs_n || rst)
        !in_stream |-> !so_oe);

    // Driving only begins once the stream phase is reached.
    assert_drive_in_stream_R3: assert property (@(posedge sck) disable iff (cs_n || rst)
        $rose(so_oe) |-> in_stream);

    // Consecutive fetches step the address by one, wrapping in its width.
    assert_addr_step_R4: assert property (@(posedge sck) disable iff (cs_n || rst)
        mem_rd_en |=> (mem_addr == $past(mem_addr) + 1'b1));

    // Fetches are never back to back.
    assert_read_spacing_R4: assert property (@(posedge sck) disable iff (cs_n || rst)
        mem_rd_en |=> !mem_rd_en);

    // A rejected or unmatched command never drives the pin.
    assert_oe_needs_accept_R7: assert property (@(posedge sck) disable iff (cs_n || rst)
        so_oe |-> acc_q);
endmodule

bind fastread_responder fastread_responder_chk u_chk (
    .sck       (sck),
    .rst       (rst),
    .cs_n      (cs_n),
    .so_oe     (so_oe),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .in_stream (in_stream),
    .acc_q     (acc_q)
);

// File: tb/sim_fastread_responder.sv
`timescale 1ns/1ps
module sim_fastread_responder;
    logic        sck = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        si = 1'b0;
    logic        busy = 1'b0;
    logic        so;
    logic        so_oe;
    logic        mem_rd_en;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rd_data = 8'h00;

    int checks = 0;
    int errors = 0;
    int rd_count = 0;
    logic [23:0] exp_rd_addr = 24'h0;

    always #4 sck = ~sck;

    fastread_responder u0 (
        .sck(sck), .rst(rst), .cs_n(cs_n), .si(si), .busy(busy),
        .so(so), .so_oe(so_oe), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rd_data(mem_rd_data)
    );

    function automatic logic [7:0] pattern(input logic [23:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ {a[19:16], a[23:20]} ^ 8'hA5;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Array model: one-edge latency, address checked against the expected sequence (R4, R5).
    always @(posedge sck) begin
        if (mem_rd_en) begin
            mem_rd_data <= pattern(mem_addr);
            check(mem_addr == exp_rd_addr, "R4/R5 read address", mem_addr, exp_rd_addr);
            exp_rd_addr = exp_rd_addr + 24'h1;
            rd_count++;
        end
    end

    // Sends one command and compares every output bit against the model (R1, R2, R3).
    task automatic run_cmd(input logic [7:0] opc, input logic [23:0] addr,
                           input bit busy_v, input int nbits);
        logic [39:0] hdr;
        bit acc;
        int reads_before;
        hdr = {opc, addr, 8'hFF};
        acc = (opc == 8'h0B) && !busy_v;
        exp_rd_addr = addr;
        reads_before = rd_count;
        @(negedge sck);
        cs_n = 1'b0;
        busy = busy_v;
        for (int i = 0; i < 40; i++) begin
            if (i != 0) @(negedge sck);
            si = hdr[39 - i];
            @(posedge sck); #1;
            check(so_oe == 1'b0, "R2 released during header", so_oe, 0);
        end
        for (int j = 0; j < nbits; j++) begin
            logic [7:0] b;
            b = pattern(addr + 24'(j / 8));
            @(posedge sck); #1;
            check(so_oe == acc, "R3/R7/R8 output enable", so_oe, acc);
            if (acc)
                check(so == b[7 - (j % 8)], "R1/R3/R4 data bit", so, b[7 - (j % 8)]);
        end
        @(negedge sck);
        cs_n = 1'b1;
        busy = 1'b0;
        #1;
        check(so_oe == 1'b0, "R6 select high releases", so_oe, 0);
        if (!acc)
            check(rd_count == reads_before, "R7/R8 no read strobe", rd_count - reads_before, 0);
        else
            check(rd_count - reads_before == (nbits + 7) / 8 + ((nbits % 8) == 0 ? 1 : 0) ||
                  rd_count - reads_before == (nbits + 7) / 8,
                  "R4 one strobe per byte", rd_count - reads_before, (nbits + 7) / 8);
    endtask

    initial begin
        repeat (3) @(posedge sck);
        #1;
        check(so_oe == 1'b0, "R9 reset output enable", so_oe, 0);
        check(mem_rd_en == 1'b0, "R9 reset read strobe", mem_rd_en, 0);
        @(negedge sck);
        rst = 1'b0;

        run_cmd(8'h0B, 24'h001234, 1'b0, 32);     // R1 R3 R4 basic stream
        run_cmd(8'h0B, 24'hFFFFFE, 1'b0, 32);     // R5 wrap across top
        run_cmd(8'h0B, 24'h7A5501, 1'b0, 13);     // R6 abort mid-byte
        run_cmd(8'h0B, 24'h000100, 1'b0, 16);     // R6 clean restart
        run_cmd(8'h0B, 24'h123456, 1'b1, 16);     // R7 busy rejects
        run_cmd(8'h03, 24'h123456, 1'b0, 16);     // R8 wrong opcode
        run_cmd(8'h0B, 24'hABCDEF, 1'b0, 24);     // R7 recovery after busy

        // R9: synchronous reset in the middle of a stream
        exp_rd_addr = 24'h000040;
        @(negedge sck);
        cs_n = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (i != 0) @(negedge sck);
            si = (i < 8) ? 8'h0B >> (7 - i) : (i < 32) ? 1'((24'h000040 >> (31 - i))) : 1'b1;
        end
        repeat (5) @(posedge sck);
        #1;
        check(so_oe == 1'b1, "R3 stream active before reset", so_oe, 1);
        @(negedge sck);
        rst = 1'b1;
        @(posedge sck);
        @(posedge sck); #1;
        check(so_oe == 1'b0, "R9 reset releases output", so_oe, 0);
        check(mem_rd_en == 1'b0, "R9 reset stops strobe", mem_rd_en, 0);
        @(negedge sck);
        rst = 1'b0;
        cs_n = 1'b1;

        run_cmd(8'h0B, 24'h00FFFF, 1'b0, 24);     // R4 carry across bytes

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge sck);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule